// File: doc/BRIEF.md
# Superblock Boundary Hasher

This block watches the committed instruction stream of a RISC core, one record per clock, and cuts it into basic blocks and superblocks. Any retired control transfer (branch or jump, taken or not) ends the current basic block, so the next retired instruction opens a new one. Basic blocks pile up into one superblock until a taken transfer jumps backward. That backward transfer is the last instruction of the superblock, and the instruction after it opens the next superblock.

Each superblock gets a signature built from the first address of every basic block inside it. The signature uses a rotate-and-XOR accumulation that restarts from a fixed seed at each superblock. When a superblock closes, the block gives a one-cycle strobe along with the signature, the number of basic blocks and the superblock's first address. A downstream pattern matcher uses this to find repeating superblock sequences. There is no back-pressure. A low `i_valid` just means no instruction retired in that cycle.

A four-state machine follows the boundaries. `IDLE` is entered on reset. `IN_BB` means inside a basic block. `BB_EDGE` means the previous instruction ended a basic block without closing the superblock. `SB_EDGE` means the previous instruction closed a superblock. On every valid instruction the machine moves as follows:
- From any state, a taken backward transfer goes to `SB_EDGE`.
- From any state, any other control transfer goes to `BB_EDGE`.
- From any state, a plain instruction goes to `IN_BB`.
- Cycles without a valid instruction keep the current state.

Top module: `sbhash_tracker`

## Requirements
- R1: Reset (synchronous, active high) clears `o_sb_valid`, `o_sb_hash`, `o_sb_bbcnt` and `o_sb_start` to zero. It also discards any partly built superblock, so the first valid instruction after reset opens both a basic block and a superblock.
- R2: A valid instruction with `i_ctl`=1, `i_taken`=1 and `i_target` <= `i_pc` closes the superblock that contains it. `o_sb_valid` is high for exactly the one cycle after the clock edge that sampled that instruction. Back-to-back closes give back-to-back pulses.
- R3: A valid control transfer that does not close the superblock ends the current basic block, and the next valid instruction starts a new basic block in the same superblock. This covers a forward taken transfer, and also a not-taken one whatever its target.
- R4: A taken target equal to the instruction's own address counts as backward.
- R5: The signature starts at 0x9E3779B9 for each superblock. For each basic-block start address `a`, in retirement order, it is updated as h = rotate_left(h, 5) XOR a. `o_sb_hash` is the value after the last basic block, including the one ended by the closing transfer.
- R6: `o_sb_bbcnt` is the number of basic blocks in the closed superblock, counting the closing one. It saturates at 255.
- R7: `o_sb_start` is the address of the first instruction of the closed superblock.
- R8: Cycles with `i_valid`=0 change no state and no output, whatever the other inputs carry.
- R9: Between strobes, `o_sb_hash`, `o_sb_bbcnt` and `o_sb_start` keep the values of the most recent close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_valid | input | 1 | An instruction retired this cycle |
| i_pc | input | 32 | Address of the retired instruction |
| i_ctl | input | 1 | The instruction is a branch or jump |
| i_taken | input | 1 | The transfer was taken |
| i_target | input | 32 | Transfer target address |
| o_sb_valid | output | 1 | One-cycle superblock close strobe |
| o_sb_hash | output | 32 | Signature of the closed superblock |
| o_sb_bbcnt | output | 8 | Basic blocks in the closed superblock (saturating) |
| o_sb_start | output | 32 | First address of the closed superblock |

## Verification
A wrong boundary state shows up at the next strobe and never earlier. A missed basic-block edge, for example, leaves out one address from the signature and gives a count that is one short. A missed superblock edge merges two superblocks into one strobe with the wrong start address. Each test sequence therefore ends in a close, and every strobe is compared on all four outputs. Strobes are also checked for absence during idle cycles carrying backward-looking garbage, and across a reset in the middle of a superblock.

// File: rtl/sbhash_pkg.sv
package sbhash_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_IN_BB   = 2'd1,
        ST_BB_EDGE = 2'd2,
        ST_SB_EDGE = 2'd3
    } trk_state_e;

endpackage

// File: rtl/sbhash_fsm.sv
module sbhash_fsm
    import sbhash_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_valid,
    input  logic [ADDR_W-1:0] i_pc,
    input  logic              i_ctl,
    input  logic              i_taken,
    input  logic [ADDR_W-1:0] i_target,
    output logic              bb_open,
    output logic              sb_open,
    output logic              sb_close
);

    trk_state_e state_q, state_d;
    logic       is_back;

    assign is_back = i_ctl && i_taken && (i_target <= i_pc);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        bb_open  = 1'b0;
        sb_open  = 1'b0;
        sb_close = 1'b0;
        if (i_valid) begin
            unique case (state_q)
                ST_IDLE, ST_SB_EDGE: begin
                    bb_open = 1'b1;
                    sb_open = 1'b1;
                end
                ST_BB_EDGE: bb_open = 1'b1;
                ST_IN_BB:   bb_open = 1'b0;
                default:    bb_open = 1'b0;
            endcase
            if (is_back) begin
                sb_close = 1'b1;
                state_d  = ST_SB_EDGE;
            end else if (i_ctl) begin
                state_d  = ST_BB_EDGE;
            end else begin
                state_d  = ST_IN_BB;
            end
        end
    end

    // R3: a non-closing transfer leaves the tracker waiting for a new basic block
    a_r3_edge_after_ctl: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_ctl && !is_back) |=> (state_q == ST_BB_EDGE));

    // R8: idle cycles freeze the tracker
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> $stable(state_q));

endmodule

// File: rtl/sbhash_accum.sv
module sbhash_accum #(
    parameter int          ADDR_W = 32,
    parameter int          HASH_W = 32,
    parameter int          CNT_W  = 8,
    parameter int          ROT    = 5,
    parameter logic [31:0] SEED   = 32'h9E37_79B9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_valid,
    input  logic [ADDR_W-1:0] i_pc,
    input  logic              bb_open,
    input  logic              sb_open,
    output logic [HASH_W-1:0] hash_eff,
    output logic [CNT_W-1:0]  cnt_eff,
    output logic [ADDR_W-1:0] start_eff
);

    localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [HASH_W-1:0] SEED_H    = HASH_W'(SEED);
    localparam int                N_CHUNK   = (ADDR_W + HASH_W - 1) / HASH_W;

    logic [HASH_W-1:0] hash_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] start_q;
    logic [HASH_W-1:0] addr_fold;
    logic [HASH_W-1:0] base_h;
    logic [CNT_W-1:0]  base_c;

    // Fit the address onto the signature width
    generate
        if (ADDR_W == HASH_W) begin : g_fold_eq
            assign addr_fold = i_pc;
        end else if (ADDR_W < HASH_W) begin : g_fold_pad
            assign addr_fold = {{(HASH_W-ADDR_W){1'b0}}, i_pc};
        end else begin : g_fold_xor
            logic [N_CHUNK*HASH_W-1:0] pc_ext;
            assign pc_ext = {{(N_CHUNK*HASH_W-ADDR_W){1'b0}}, i_pc};
            always_comb begin
                addr_fold = '0;
                for (int k = 0; k < N_CHUNK; k++)
                    addr_fold = addr_fold ^ pc_ext[k*HASH_W +: HASH_W];
            end
        end
    endgenerate

    function automatic logic [HASH_W-1:0] mix(input logic [HASH_W-1:0] h,
                                              input logic [HASH_W-1:0] a);
        return ((h << ROT) | (h >> (HASH_W - ROT))) ^ a;
    endfunction

    always_comb begin
        base_h    = sb_open ? SEED_H : hash_q;
        base_c    = sb_open ? '0 : cnt_q;
        start_eff = sb_open ? i_pc : start_q;
        hash_eff  = bb_open ? mix(base_h, addr_fold) : base_h;
        cnt_eff   = (bb_open && base_c != CNT_MAX) ? base_c + 1'b1 : base_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hash_q  <= SEED_H;
            cnt_q   <= '0;
            start_q <= '0;
        end else if (i_valid) begin
            hash_q  <= hash_eff;
            cnt_q   <= cnt_eff;
            start_q <= start_eff;
        end
    end

    // R6: a saturated count stays saturated until a new superblock opens
    a_r6_sat_hold: assert property (@(posedge clk) disable iff (rst)
        (i_valid && !sb_open && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    // R1: a fresh superblock holds exactly one basic block after its first instruction
    a_r1_fresh_count: assert property (@(posedge clk) disable iff (rst)
        (i_valid && sb_open) |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/sbhash_emit.sv
module sbhash_emit #(
    parameter int ADDR_W = 32,
    parameter int HASH_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sb_close,
    input  logic [HASH_W-1:0] hash_eff,
    input  logic [CNT_W-1:0]  cnt_eff,
    input  logic [ADDR_W-1:0] start_eff,
    output logic              o_valid,
    output logic [HASH_W-1:0] o_hash,
    output logic [CNT_W-1:0]  o_cnt,
    output logic [ADDR_W-1:0] o_start
);

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_hash  <= '0;
            o_cnt   <= '0;
            o_start <= '0;
        end else begin
            o_valid <= sb_close;
            if (sb_close) begin
                o_hash  <= hash_eff;
                o_cnt   <= cnt_eff;
                o_start <= start_eff;
            end
        end
    end

    // R9: payload only moves together with a strobe
    a_r9_payload_hold: assert property (@(posedge clk) disable iff (rst)
        !o_valid |-> ($stable(o_hash) && $stable(o_cnt) && $stable(o_start)));

endmodule

// File: rtl/sbhash_tracker.sv
module sbhash_tracker #(
    parameter int          ADDR_W = 32,
    parameter int          HASH_W = 32,
    parameter int          CNT_W  = 8,
    parameter int          ROT    = 5,
    parameter logic [31:0] SEED   = 32'h9E37_79B9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_valid,
    input  logic [ADDR_W-1:0] i_pc,
    input  logic              i_ctl,
    input  logic              i_taken,
    input  logic [ADDR_W-1:0] i_target,
    output logic              o_sb_valid,
    output logic [HASH_W-1:0] o_sb_hash,
    output logic [CNT_W-1:0]  o_sb_bbcnt,
    output logic [ADDR_W-1:0] o_sb_start
);

    logic              bb_open, sb_open, sb_close;
    logic [HASH_W-1:0] hash_eff;
    logic [CNT_W-1:0]  cnt_eff;
    logic [ADDR_W-1:0] start_eff;

    sbhash_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_pc(i_pc), .i_ctl(i_ctl),
        .i_taken(i_taken), .i_target(i_target),
        .bb_open(bb_open), .sb_open(sb_open), .sb_close(sb_close)
    );

    sbhash_accum #(.ADDR_W(ADDR_W), .HASH_W(HASH_W), .CNT_W(CNT_W),
                   .ROT(ROT), .SEED(SEED)) u_acc (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_pc(i_pc),
        .bb_open(bb_open), .sb_open(sb_open),
        .hash_eff(hash_eff), .cnt_eff(cnt_eff), .start_eff(start_eff)
    );

    sbhash_emit #(.ADDR_W(ADDR_W), .HASH_W(HASH_W), .CNT_W(CNT_W)) u_emit (
        .clk(clk), .rst(rst), .sb_close(sb_close),
        .hash_eff(hash_eff), .cnt_eff(cnt_eff), .start_eff(start_eff),
        .o_valid(o_sb_valid), .o_hash(o_sb_hash), .o_cnt(o_sb_bbcnt),
        .o_start(o_sb_start)
    );

    // R2: every strobe is caused by a taken backward transfer one cycle earlier
    a_r2_strobe_cause: assert property (@(posedge clk) disable iff (rst)
        o_sb_valid |-> $past(i_valid && i_ctl && i_taken && (i_target <= i_pc)));

    // R2 / R6: a backward transfer yields a strobe reporting a non-empty superblock
    a_r2_close_strobe: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_ctl && i_taken && (i_target <= i_pc))
            |=> (o_sb_valid && o_sb_bbcnt != '0));

endmodule

// File: tb/sbhash_tracker_tb_top.sv
module sbhash_tracker_tb_top;

    typedef struct packed {
        logic [31:0] pc;
        logic        ctl;
        logic        tk;
        logic [31:0] tgt;
        logic        close;
        logic [7:0]  cnt;
        logic [31:0] start;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{32'h100, 1'b0, 1'b0, 32'h0,   1'b0, 8'd0, 32'h0},
        '{32'h104, 1'b1, 1'b1, 32'h200, 1'b0, 8'd0, 32'h0},
        '{32'h200, 1'b0, 1'b0, 32'h0,   1'b0, 8'd0, 32'h0},
        '{32'h204, 1'b1, 1'b0, 32'h100, 1'b0, 8'd0, 32'h0},
        '{32'h208, 1'b1, 1'b1, 32'h100, 1'b1, 8'd3, 32'h100},
        '{32'h100, 1'b1, 1'b1, 32'h100, 1'b1, 8'd1, 32'h100},
        '{32'h100, 1'b0, 1'b0, 32'h0,   1'b0, 8'd0, 32'h0},
        '{32'h104, 1'b1, 1'b1, 32'h080, 1'b1, 8'd1, 32'h100},
        '{32'h080, 1'b1, 1'b1, 32'h300, 1'b0, 8'd0, 32'h0},
        '{32'h300, 1'b1, 1'b1, 32'h080, 1'b1, 8'd2, 32'h080}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        i_valid = 1'b0, i_ctl = 1'b0, i_taken = 1'b0;
    logic [31:0] i_pc = '0, i_target = '0;
    logic        o_sb_valid;
    logic [31:0] o_sb_hash, o_sb_start;
    logic [7:0]  o_sb_bbcnt;

    int total = 0;
    int bad   = 0;

    // reference state, written from the requirements
    logic [31:0] m_h;
    logic        m_sbnew, m_bbnew;

    always #4 clk = ~clk;

    sbhash_tracker dut_i (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_pc(i_pc), .i_ctl(i_ctl),
        .i_taken(i_taken), .i_target(i_target), .o_sb_valid(o_sb_valid),
        .o_sb_hash(o_sb_hash), .o_sb_bbcnt(o_sb_bbcnt), .o_sb_start(o_sb_start)
    );

    function automatic logic [31:0] rmix(input logic [31:0] h, input logic [31:0] a);
        return {h[26:0], h[31:27]} ^ a;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one instruction at a falling edge, sample mid-cycle after the next rising edge
    task automatic send(input logic [31:0] pc, input logic ctl, input logic tk,
                        input logic [31:0] tgt, input logic chk, input logic close,
                        input logic [7:0] cnt, input logic [31:0] start, input string req);
        i_valid = 1'b1; i_pc = pc; i_ctl = ctl; i_taken = tk; i_target = tgt;
        if (m_sbnew) m_h = 32'h9E37_79B9;
        if (m_bbnew) m_h = rmix(m_h, pc);
        m_sbnew = ctl && tk && (tgt <= pc);
        m_bbnew = ctl;
        @(posedge clk);
        #2;
        if (chk) begin
            check({req, " strobe"}, {31'd0, o_sb_valid}, {31'd0, close});
            if (close) begin
                check({req, " R5 hash"}, o_sb_hash, m_h);
                check({req, " R6 count"}, {24'd0, o_sb_bbcnt}, {24'd0, cnt});
                check({req, " R7 start"}, o_sb_start, start);
            end
        end
        @(negedge clk);
        i_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        m_sbnew = 1'b1; m_bbnew = 1'b1; m_h = 32'h9E37_79B9;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] h_keep;
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 valid", {31'd0, o_sb_valid}, 32'd0);
        check("R1 hash", o_sb_hash, 32'd0);
        check("R1 count", {24'd0, o_sb_bbcnt}, 32'd0);
        check("R1 start", o_sb_start, 32'd0);

        // vector table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++)
            send(VEC[i].pc, VEC[i].ctl, VEC[i].tk, VEC[i].tgt, 1'b1,
                 VEC[i].close, VEC[i].cnt, VEC[i].start, "R2/R3/R4 vec");

        // R4 + R5 with literal signature: one-instruction loop at 0x100
        send(32'h100, 1'b1, 1'b1, 32'h100, 1'b1, 1'b1, 8'd1, 32'h100, "R4 self loop");
        check("R5 literal", o_sb_hash, 32'hC6EF_3633);

        // R2 strobe lasts one cycle
        @(posedge clk); #2;
        check("R2 one cycle", {31'd0, o_sb_valid}, 32'd0);
        @(negedge clk);

        // R8 / R9: idle cycles carrying backward-looking garbage
        send(32'h400, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 8'd0, 32'h0, "R3 open");
        h_keep = o_sb_hash;
        i_valid = 1'b0; i_pc = 32'h900; i_ctl = 1'b1; i_taken = 1'b1; i_target = 32'h10;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); #2;
            check("R8 no strobe when idle", {31'd0, o_sb_valid}, 32'd0);
            check("R9 hash held", o_sb_hash, h_keep);
            @(negedge clk);
        end
        send(32'h404, 1'b1, 1'b1, 32'h400, 1'b1, 1'b1, 8'd1, 32'h400, "R8 after gap");

        // R6 saturation: 299 forward jumps, then a backward close
        for (int k = 0; k < 299; k++)
            send(32'h1000 + 32'(k) * 32'h10, 1'b1, 1'b1, 32'h1000 + 32'(k+1) * 32'h10,
                 1'b1, 1'b0, 8'd0, 32'h0, "R3 fwd chain");
        send(32'h1000 + 32'd299 * 32'h10, 1'b1, 1'b1, 32'h1000, 1'b1, 1'b1,
             8'd255, 32'h1000, "R6 saturate");

        // R1: reset in the middle of a superblock discards it
        send(32'h700, 1'b1, 1'b1, 32'h800, 1'b0, 1'b0, 8'd0, 32'h0, "pre-reset");
        send(32'h800, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 8'd0, 32'h0, "pre-reset");
        do_reset();
        check("R1 cleared after reset", o_sb_hash, 32'd0);
        send(32'h500, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 8'd0, 32'h0, "R1 first");
        send(32'h504, 1'b1, 1'b1, 32'h500, 1'b1, 1'b1, 8'd1, 32'h500, "R1 fresh superblock");
        check("R1 literal hash", o_sb_hash, 32'hC6EF_3233);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule